// File: doc/BRIEF.md
# Runtime-Selectable Width Adapter with Slice Ordering

This block sits on one side of a pair of opposing 36-bit FIFOs. It lets the external port on that side run 36, 18 or 9 bits wide. In the ingress direction it collects two or four narrow transfers into one full word and then issues a single write to the FIFO. In the egress direction it takes one full word from the FIFO and hands it out as two or four narrow transfers. The FIFOs themselves and the port on the far side stay 36 bits wide and are not part of this block.

A second setting picks which end of the word travels first. With most-significant-first ordering the upper slice leads. With least-significant-first ordering the lower slice leads. The same width and ordering apply to both directions. Every side of the block uses valid/ready handshakes. Both settings are sampled only while reset is held, and reset also throws away any word that is only partly built.

Top module: `bus_width_adapter`

## Requirements
- R1: `cfg_width` (00 = 36 bits, 01 = 18 bits, 10 = 9 bits, 11 = 36 bits) and `cfg_big_endian` (1 = most significant slice first) are captured on every clock edge while `rst_n` is low. Changes to them while `rst_n` is high have no effect on the behaviour.
- R2: In 36-bit mode both directions pass through in the same cycle. Valid, data and ready are joined combinationally, so each FIFO word takes one transfer and no cycle is added.
- R3: In a narrow mode each ingress slice sits in bits [17:0] (18-bit) or [8:0] (9-bit) of `ext_in_data`, and the upper bits are ignored. After 2 (18-bit) or 4 (9-bit) accepted slices, one full word is presented on `fifo_wr_data`. `fifo_wr_valid` rises on the clock edge that accepts the last slice, and never earlier.
- R4: With `cfg_big_endian` = 0, the ingress slice accepted k-th (k from 0) lands in bits [k*S +: S] of the packed word, where S is the slice width.
- R5: With `cfg_big_endian` = 1, the ingress slice accepted k-th lands in bits [(N-1-k)*S +: S], where N is the number of slices per word.
- R6: In a narrow mode, `fifo_rd_ready` is high only while no egress word is held. A popped word is offered as N transfers on `ext_out_data` starting the next cycle, and the next word is popped only after its last slice has been accepted.
- R7: Egress slices follow the same slot rule as R4/R5. The k-th transfer carries slot k (least-significant-first) or slot N-1-k (most-significant-first), placed in the low S bits, with the upper bits of `ext_out_data` driven to zero.
- R8: While `fifo_wr_valid` or `ext_out_valid` is high and the matching ready is low, the valid stays high and the data stays unchanged on the next cycle.
- R9: In a narrow mode, `ext_in_ready` is low from the edge that completes a word until the edge on which `fifo_wr_ready` accepts it.
- R10: Reset discards any partly packed word and any partly sent egress word. On the first cycle after reset, `fifo_wr_valid` and `ext_out_valid` are low, and the next word is built only from slices accepted after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfg_width | input | 2 | External port width code |
| cfg_big_endian | input | 1 | 1 = most significant slice moves first |
| ext_in_data | input | 36 | Ingress data from the external port; narrow slices in the low bits |
| ext_in_valid | input | 1 | Ingress slice or word valid |
| ext_in_ready | output | 1 | Adapter can accept an ingress transfer |
| fifo_wr_data | output | 36 | Full word written to the ingress FIFO |
| fifo_wr_valid | output | 1 | FIFO write request |
| fifo_wr_ready | input | 1 | Ingress FIFO accepts the word |
| fifo_rd_data | input | 36 | Full word from the egress FIFO |
| fifo_rd_valid | input | 1 | Egress FIFO has a word |
| fifo_rd_ready | output | 1 | Adapter pops the egress word |
| ext_out_data | output | 36 | Egress data; narrow slices in the low bits, upper bits zero |
| ext_out_valid | output | 1 | Egress transfer valid |
| ext_out_ready | input | 1 | External sink accepts the transfer |

## Verification
In 36-bit mode every output is due in the same cycle as its input. In narrow modes, `fifo_wr_valid` and the drop of `ext_in_ready` are due one edge after the last slice is accepted, and the first egress slice is due one edge after a FIFO pop. The bench drives inputs on the falling edge and samples 1 ns later, ahead of the next rising edge. At that moment its queue model holds exactly the words and slices already committed by earlier edges. Valid, ready and data are compared against that model every cycle, before the handshakes of the current cycle are applied to it, so any result a cycle early or late is flagged.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

  typedef enum logic [1:0] {
    WM_FULL    = 2'b00,
    WM_HALF    = 2'b01,
    WM_QUARTER = 2'b10
  } wmode_e;

  // width code to mode; the spare code behaves as full width
  function automatic wmode_e decode_width(logic [1:0] code);
    case (code)
      2'b01:   return WM_HALF;
      2'b10:   return WM_QUARTER;
      default: return WM_FULL;
    endcase
  endfunction

  // number of external transfers per internal word
  function automatic logic [2:0] piece_count(wmode_e m);
    case (m)
      WM_HALF:    return 3'd2;
      WM_QUARTER: return 3'd4;
      default:    return 3'd1;
    endcase
  endfunction

  // word slot touched by the idx-th transfer
  function automatic logic [1:0] slot_for(logic [1:0] idx, logic [2:0] n, logic big);
    logic [2:0] s;
    s = big ? (n - 3'd1 - {1'b0, idx}) : {1'b0, idx};
    return s[1:0];
  endfunction

  function automatic logic is_last(logic [1:0] idx, logic [2:0] n);
    return ({1'b0, idx} == (n - 3'd1));
  endfunction

endpackage

// File: rtl/bwa_cfg_latch.sv
module bwa_cfg_latch
  import bwa_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] cfg_width,
  input  logic       cfg_big_endian,
  output wmode_e     mode,
  output logic       big
);

  wmode_e mode_q;
  logic   big_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= decode_width(cfg_width);
      big_q  <= cfg_big_endian;
    end
  end

  assign mode = mode_q;
  assign big  = big_q;

  // R1
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($stable(mode_q) && $stable(big_q)));

endmodule

// File: rtl/bwa_packer.sv
module bwa_packer
  import bwa_pkg::*;
#(
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wmode_e            mode,
  input  logic              big,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              slice_take,
  output logic              word_push
);

  localparam int HW = WORD_W / 2;
  localparam int QW = WORD_W / 4;

  logic [WORD_W-1:0] acc_q;
  logic [1:0]        cnt_q;
  logic              done_q;
  logic              narrow;
  logic [2:0]        n_pieces;
  logic [1:0]        slot;
  logic              last_slice;

  assign narrow     = (mode != WM_FULL);
  assign n_pieces   = piece_count(mode);
  assign slot       = slot_for(cnt_q, n_pieces, big);
  assign last_slice = is_last(cnt_q, n_pieces);

  assign in_ready  = narrow ? !done_q : out_ready;
  assign out_valid = narrow ? done_q  : in_valid;
  assign out_data  = narrow ? acc_q   : in_data;

  assign slice_take = narrow && in_valid && !done_q;
  assign word_push  = narrow && done_q && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (slice_take) begin
        case (mode)
          WM_HALF:    acc_q[int'(slot)*HW +: HW] <= in_data[HW-1:0];
          WM_QUARTER: acc_q[int'(slot)*QW +: QW] <= in_data[QW-1:0];
          default:    ;
        endcase
        if (last_slice) begin
          cnt_q  <= '0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 2'd1;
        end
      end
      if (word_push) done_q <= 1'b0;
    end
  end

  // slices taken since the previous push, kept for the checks only
  logic [2:0] take_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)          take_cnt <= '0;
    else if (word_push)  take_cnt <= '0;
    else if (slice_take) take_cnt <= take_cnt + 3'd1;
  end

  // R3
  pack_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_push |-> (take_cnt == n_pieces));

  // R9
  pack_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (narrow && out_valid && !out_ready) |=> !in_ready);

  // R8
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && narrow) |=> (out_valid && $stable(out_data)));

  // R2
  wr_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!narrow && in_valid && in_ready) |-> (out_valid && out_ready && out_data == in_data));

endmodule

// File: rtl/bwa_unpacker.sv
module bwa_unpacker
  import bwa_pkg::*;
#(
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wmode_e            mode,
  input  logic              big,
  input  logic [WORD_W-1:0] word_data,
  input  logic              word_valid,
  output logic              word_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              word_pop,
  output logic              slice_give
);

  localparam int HW = WORD_W / 2;
  localparam int QW = WORD_W / 4;

  logic [WORD_W-1:0] hold_q;
  logic              have_q;
  logic [1:0]        cnt_q;
  logic              narrow;
  logic [2:0]        n_pieces;
  logic [1:0]        slot;
  logic              last_slice;
  logic [WORD_W-1:0] slice_out;

  assign narrow     = (mode != WM_FULL);
  assign n_pieces   = piece_count(mode);
  assign slot       = slot_for(cnt_q, n_pieces, big);
  assign last_slice = is_last(cnt_q, n_pieces);

  always_comb begin
    slice_out = '0;
    case (mode)
      WM_HALF:    slice_out[HW-1:0] = hold_q[int'(slot)*HW +: HW];
      WM_QUARTER: slice_out[QW-1:0] = hold_q[int'(slot)*QW +: QW];
      default:    slice_out = hold_q;
    endcase
  end

  assign word_ready = narrow ? !have_q   : out_ready;
  assign out_valid  = narrow ? have_q    : word_valid;
  assign out_data   = narrow ? slice_out : word_data;

  assign word_pop   = narrow && word_valid && !have_q;
  assign slice_give = narrow && have_q && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      have_q <= 1'b0;
      cnt_q  <= '0;
    end else if (word_pop) begin
      hold_q <= word_data;
      have_q <= 1'b1;
      cnt_q  <= '0;
    end else if (slice_give) begin
      if (last_slice) begin
        have_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 2'd1;
      end
    end
  end

  // transfers handed out since the previous pop, kept for the checks only
  logic [2:0] give_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)          give_cnt <= '0;
    else if (word_pop)   give_cnt <= '0;
    else if (slice_give) give_cnt <= give_cnt + 3'd1;
  end

  // R6
  unpack_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slice_give |-> (give_cnt < n_pieces));

  // R6
  unpack_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_pop |=> (out_valid && !word_ready));

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && narrow) |=> (out_valid && $stable(out_data)));

  // R7
  out_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (narrow && out_valid) |-> (out_data[WORD_W-1:HW] == '0));

endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter
  import bwa_pkg::*;
#(
  parameter int WORD_W = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_big_endian,
  input  logic [WORD_W-1:0] ext_in_data,
  input  logic              ext_in_valid,
  output logic              ext_in_ready,
  output logic [WORD_W-1:0] fifo_wr_data,
  output logic              fifo_wr_valid,
  input  logic              fifo_wr_ready,
  input  logic [WORD_W-1:0] fifo_rd_data,
  input  logic              fifo_rd_valid,
  output logic              fifo_rd_ready,
  output logic [WORD_W-1:0] ext_out_data,
  output logic              ext_out_valid,
  input  logic              ext_out_ready
);

  wmode_e mode;
  logic   big;
  logic   pk_take, pk_push, up_pop, up_give;

  bwa_cfg_latch u_cfg (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_width      (cfg_width),
    .cfg_big_endian (cfg_big_endian),
    .mode           (mode),
    .big            (big)
  );

  bwa_packer #(.WORD_W(WORD_W)) u_pack (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .big        (big),
    .in_data    (ext_in_data),
    .in_valid   (ext_in_valid),
    .in_ready   (ext_in_ready),
    .out_data   (fifo_wr_data),
    .out_valid  (fifo_wr_valid),
    .out_ready  (fifo_wr_ready),
    .slice_take (pk_take),
    .word_push  (pk_push)
  );

  bwa_unpacker #(.WORD_W(WORD_W)) u_unpack (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .big        (big),
    .word_data  (fifo_rd_data),
    .word_valid (fifo_rd_valid),
    .word_ready (fifo_rd_ready),
    .out_data   (ext_out_data),
    .out_valid  (ext_out_valid),
    .out_ready  (ext_out_ready),
    .word_pop   (up_pop),
    .slice_give (up_give)
  );

  // R10
  rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !(pk_push || up_give));

endmodule

// File: tb/sim_bus_width_adapter.sv
`timescale 1ns/1ps
module sim_bus_width_adapter;
  localparam int W = 36;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   cfg_width = 2'b00;
  logic         cfg_big_endian = 1'b0;
  logic [W-1:0] ext_in_data = '0;
  logic         ext_in_valid = 1'b0;
  logic         ext_in_ready;
  logic [W-1:0] fifo_wr_data;
  logic         fifo_wr_valid;
  logic         fifo_wr_ready = 1'b0;
  logic [W-1:0] fifo_rd_data = '0;
  logic         fifo_rd_valid = 1'b0;
  logic         fifo_rd_ready;
  logic [W-1:0] ext_out_data;
  logic         ext_out_valid;
  logic         ext_out_ready = 1'b0;

  always #2.5 clk = ~clk;

  bus_width_adapter u0 (.*);

  int n_checks = 0, n_fail = 0;
  int m_n = 1;  bit m_big = 0;
  logic [W-1:0] wq[$];
  logic [W-1:0] sq[$];
  int pk_idx = 0;  logic [63:0] pk_acc = '0;
  logic [W-1:0] last_wr = '0;
  bit in_fired = 0, rd_fired = 0;
  bit prev_wr_stall = 0, prev_out_stall = 0;
  logic [W-1:0] prev_wr_data = '0, prev_out_data = '0;
  int dir_val = 1, dir_lim = 0;

  task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit in_fire, wr_fire, rd_fire, out_fire;
    int w;
    logic [63:0] mask;
    string tp, to;
    in_fire  = ext_in_valid && ext_in_ready;
    wr_fire  = fifo_wr_valid && fifo_wr_ready;
    rd_fire  = fifo_rd_valid && fifo_rd_ready;
    out_fire = ext_out_valid && ext_out_ready;
    w = W / m_n;
    mask = (64'd1 << w) - 64'd1;
    tp = m_big ? "R5" : "R4";
    to = "R7";
    if (prev_wr_stall) chk(fifo_wr_valid && fifo_wr_data == prev_wr_data, "R8", fifo_wr_data, prev_wr_data);
    if (prev_out_stall) chk(ext_out_valid && ext_out_data == prev_out_data, "R8", ext_out_data, prev_out_data);
    if (m_n == 1) begin
      chk(fifo_wr_valid == ext_in_valid && ext_in_ready == fifo_wr_ready, "R2",
          W'({fifo_wr_valid, ext_in_ready}), W'({ext_in_valid, fifo_wr_ready}));
      if (ext_in_valid) chk(fifo_wr_data == ext_in_data, "R2", fifo_wr_data, ext_in_data);
      chk(ext_out_valid == fifo_rd_valid && fifo_rd_ready == ext_out_ready, "R2",
          W'({ext_out_valid, fifo_rd_ready}), W'({fifo_rd_valid, ext_out_ready}));
      if (fifo_rd_valid) chk(ext_out_data == fifo_rd_data, "R2", ext_out_data, fifo_rd_data);
      if (wr_fire) last_wr = fifo_wr_data;
    end else begin
      chk(fifo_wr_valid == (wq.size() > 0), "R3", W'(fifo_wr_valid), W'(wq.size() > 0));
      chk(ext_in_ready == (wq.size() == 0), "R9", W'(ext_in_ready), W'(wq.size() == 0));
      if (fifo_wr_valid && wq.size() > 0) chk(fifo_wr_data == wq[0], tp, fifo_wr_data, wq[0]);
      if (wr_fire) begin
        last_wr = fifo_wr_data;
        if (wq.size() > 0) void'(wq.pop_front());
      end
      if (in_fire) begin
        int slot;
        slot = m_big ? (m_n - 1 - pk_idx) : pk_idx;
        pk_acc = pk_acc | ((64'(ext_in_data) & mask) << (slot * w));
        pk_idx++;
        if (pk_idx == m_n) begin
          wq.push_back(W'(pk_acc));
          pk_acc = '0;
          pk_idx = 0;
        end
      end
      chk(ext_out_valid == (sq.size() > 0), "R6", W'(ext_out_valid), W'(sq.size() > 0));
      chk(fifo_rd_ready == (sq.size() == 0), "R6", W'(fifo_rd_ready), W'(sq.size() == 0));
      if (ext_out_valid && sq.size() > 0) chk(ext_out_data == sq[0], to, ext_out_data, sq[0]);
      if (out_fire && sq.size() > 0) void'(sq.pop_front());
      if (rd_fire) begin
        for (int k = 0; k < m_n; k++) begin
          int slot;
          slot = m_big ? (m_n - 1 - k) : k;
          sq.push_back(W'((64'(fifo_rd_data) >> (slot * w)) & mask));
        end
      end
    end
    prev_wr_stall  = fifo_wr_valid && !fifo_wr_ready;
    prev_wr_data   = fifo_wr_data;
    prev_out_stall = ext_out_valid && !ext_out_ready;
    prev_out_data  = ext_out_data;
    in_fired = in_fire;
    rd_fired = rd_fire;
  endtask

  task automatic run_cycles(int cyc, bit directed);
    for (int c = 0; c < cyc; c++) begin
      @(negedge clk);
      if (!ext_in_valid || in_fired) begin
        if (directed) begin
          if (dir_val <= dir_lim) begin
            ext_in_valid = 1'b1;
            ext_in_data  = {W'({$urandom(), $urandom()}) & ~W'(36'h1FF)} | W'(dir_val);
            if (m_n == 2) ext_in_data = {$urandom(), 18'h0} | W'(dir_val);
            dir_val++;
          end else begin
            ext_in_valid = 1'b0;
          end
        end else begin
          ext_in_valid = ($urandom() % 4) != 0;
          ext_in_data  = W'({$urandom(), $urandom()});
        end
      end
      if (!fifo_rd_valid || rd_fired) begin
        fifo_rd_valid = directed ? 1'b0 : (($urandom() % 3) != 0);
        fifo_rd_data  = W'({$urandom(), $urandom()});
      end
      fifo_wr_ready = directed ? 1'b1 : (($urandom() % 3) != 0);
      ext_out_ready = ($urandom() % 3) != 0;
      #1;
      model_step();
    end
  endtask

  task automatic do_reset(logic [1:0] wcode, bit be);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_width = wcode;
    cfg_big_endian = be;
    ext_in_valid = 1'b0;
    fifo_rd_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wq.delete(); sq.delete();
    pk_idx = 0; pk_acc = '0;
    in_fired = 0; rd_fired = 0;
    prev_wr_stall = 0; prev_out_stall = 0;
    m_n = (wcode == 2'b01) ? 2 : (wcode == 2'b10) ? 4 : 1;
    m_big = be;
    #1;
    // R10: nothing pending right after reset
    chk(!fifo_wr_valid && !ext_out_valid, "R10", W'({fifo_wr_valid, ext_out_valid}), '0);
  endtask

  task automatic directed_word(int lim);
    dir_val = 1;
    dir_lim = lim;
    run_cycles(lim + 4, 1'b1);
  endtask

  localparam logic [W-1:0] LE9  = (36'd4 << 27) | (36'd3 << 18) | (36'd2 << 9) | 36'd1;
  localparam logic [W-1:0] BE9  = (36'd1 << 27) | (36'd2 << 18) | (36'd3 << 9) | 36'd4;
  localparam logic [W-1:0] LE18 = (36'd2 << 18) | 36'd1;
  localparam logic [W-1:0] BE18 = (36'd1 << 18) | 36'd2;

  initial begin
    // 36-bit pass-through
    do_reset(2'b00, 1'b0);
    run_cycles(300, 1'b0);
    do_reset(2'b11, 1'b1);
    run_cycles(100, 1'b0);

    // 18-bit little, directed then random
    do_reset(2'b01, 1'b0);
    directed_word(2);
    chk(last_wr == LE18, "R4", last_wr, LE18);
    run_cycles(400, 1'b0);

    // 18-bit big
    do_reset(2'b01, 1'b1);
    directed_word(2);
    chk(last_wr == BE18, "R5", last_wr, BE18);
    run_cycles(400, 1'b0);

    // 9-bit little
    do_reset(2'b10, 1'b0);
    directed_word(4);
    chk(last_wr == LE9, "R4", last_wr, LE9);
    run_cycles(400, 1'b0);

    // 9-bit big
    do_reset(2'b10, 1'b1);
    directed_word(4);
    chk(last_wr == BE9, "R5", last_wr, BE9);
    run_cycles(400, 1'b0);

    // R1: settings changed after reset are ignored
    do_reset(2'b10, 1'b1);
    cfg_width = 2'b00;
    cfg_big_endian = 1'b0;
    directed_word(4);
    chk(last_wr == BE9, "R1", last_wr, BE9);
    run_cycles(200, 1'b0);

    // R10: partial word dropped by reset
    do_reset(2'b10, 1'b0);
    last_wr = '0;
    directed_word(2);
    chk(!fifo_wr_valid && last_wr == '0, "R10", last_wr, '0);
    do_reset(2'b10, 1'b0);
    directed_word(4);
    chk(last_wr == LE9, "R10", last_wr, LE9);
    run_cycles(200, 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule